// File: doc/BRIEF.md
# Latched Link Status Register

This block is a read-only 16-bit status word. It collects the live link indications of one twisted-pair port and one fiber port. The underlying detectors (PLL lock tracking, frequency checks, speed sensing, pulse-burst sensing, packet sensing) sit outside the block, and their raw outputs arrive as plain level inputs. Each bit follows one of three rules:

- **Plain:** the bit shows its input one clock later.
- **Latch high:** the bit is held at 1 until the host reads the word.
- **Latch low:** the bit is held at 0 until the host reads the word.

Two of the bits are also forced to 0 while the transparent mode select is high. The two packet-seen bits are qualified by the speed indications of their own port.

The host reads by raising `rd_stb_i` for one clock. The value it captures is `status_o` as presented during that cycle. At the closing edge of that cycle every latch re-arms: from the next cycle each latched bit again reflects the present condition. If the condition is still active at the re-arm, the bit latches again at once, so no event is lost between reads.

All pins are plain control and status levels. There is no streaming data path, so no valid/ready handshake is used, and the read strobe is never back-pressured.

Top module: `lnk_stat_reg`

## Requirements
- R1: While `rst_n` is low, `status_o` is 0, and every latched bit starts from 0 when reset is released.
- R2: Bits 15, 14, 13, 12, 11, 7, 6, 4, 3, 2 and 0 each show their raw input as registered at the previous rising clock edge. The bit positions are:
  - 15: fiber PLL on local oscillator
  - 14: fiber frequency error
  - 13: remote fault
  - 12: twisted-pair PLL on local oscillator
  - 11: twisted-pair frequency error
  - 7: twisted-pair 100 Mb/s
  - 6: twisted-pair 10 Mb/s
  - 4: twisted-pair pulse bursts
  - 3: fiber 100 Mb/s
  - 2: fiber 10 Mb/s
  - 0: fiber pulse bursts
- R3: Bit 9 (twisted-pair link up) latches low. It goes to 0 on the clock after the link input is low. It then stays 0, even when the link input returns, until a read. On the clock after a read it equals the link input.
- R4: While `transparent_i` is high, bits 9 and 8 read 0 on the following clock.
- R5: Bit 8 (auto-negotiation done) equals the registered value of `tp_aneg_done_i` AND NOT `transparent_i`.
- R6: Bit 5 (twisted-pair packet seen) latches high until a read. It is 0 on the clock after both twisted-pair speed inputs are low.
- R7: Bit 1 (fiber packet seen) latches high until a read. It is 0 on the clock after both fiber speed inputs are low.
- R8: Bit 10 (descrambler seed stall) latches high until a read.
- R9: A read captures `status_o` as presented during the `rd_stb_i` cycle. Latches re-arm at that cycle's closing edge. A condition still present in the read cycle sets its latched bit again on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| transparent_i | input | 1 | 1 selects transparent mode |
| rd_stb_i | input | 1 | Host read strobe, one cycle per read |
| fx_lo_track_i | input | 1 | Fiber PLL following local oscillator |
| fx_freq_err_i | input | 1 | Fiber PLL frequency out of range |
| fx_remote_fault_i | input | 1 | Remote fault pattern seen on fiber |
| tp_lo_track_i | input | 1 | Twisted-pair PLL following local oscillator |
| tp_freq_err_i | input | 1 | Twisted-pair PLL frequency out of range |
| seed_stall_i | input | 1 | Descrambler seed not refreshed in time |
| tp_link_up_i | input | 1 | Twisted-pair link up |
| tp_aneg_done_i | input | 1 | Auto-negotiation complete |
| tp_rate100_i | input | 1 | 100 Mb/s seen on twisted pair |
| tp_rate10_i | input | 1 | 10 Mb/s seen on twisted pair |
| tp_pkt_seen_i | input | 1 | Packet seen on twisted pair |
| tp_pulse_burst_i | input | 1 | Link pulse bursts on twisted pair |
| fx_rate100_i | input | 1 | 100 Mb/s seen on fiber |
| fx_rate10_i | input | 1 | 10 Mb/s seen on fiber |
| fx_pkt_seen_i | input | 1 | Packet seen on fiber |
| fx_pulse_burst_i | input | 1 | Link pulse bursts on fiber |
| status_o | output | 16 | Status word |

## Verification
The read re-arm can fall in the same cycle as a change in a latched condition. Examples are a read strobe while the packet or seed-stall input is still high, and a read strobe in the cycle where the link drops.

The bench drives these coincidences on purpose:
- **Read during an active event:** the bit must be set again on the next clock.
- **Read while the link falls:** bit 9 must be 0 on the next clock.
- **Read while the link is up:** bit 9 must turn 1 at the re-arm.

The bench also samples `status_o` just after raising the strobe, before the edge, to confirm that the host captures the held value rather than the refreshed one.

// File: rtl/lnk_stat_pkg.sv
package lnk_stat_pkg;
  localparam int STAT_W = 16;

  // bit positions of the status word
  localparam int B_FX_LO     = 15;
  localparam int B_FX_FERR   = 14;
  localparam int B_REM_FLT   = 13;
  localparam int B_TP_LO     = 12;
  localparam int B_TP_FERR   = 11;
  localparam int B_SEED      = 10;
  localparam int B_LINK      = 9;
  localparam int B_ANEG      = 8;
  localparam int B_TP_100    = 7;
  localparam int B_TP_10     = 6;
  localparam int B_TP_PKT    = 5;
  localparam int B_TP_BURST  = 4;
  localparam int B_FX_100    = 3;
  localparam int B_FX_10     = 2;
  localparam int B_FX_PKT    = 1;
  localparam int B_FX_BURST  = 0;

  // count of bits per rule
  localparam int LIVE_N = 12;  // eleven plain bits plus gated aneg
  localparam int HOLD_N = 3;   // latch-high bits: seed, tp pkt, fx pkt
endpackage

// File: rtl/lnk_stat_live.sv
module lnk_stat_live #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= d_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_chk
    // R2
    live_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      d_i[i] |=> q_o[i]);
    // R2
    live_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !d_i[i] |=> !q_o[i]);
  end
endmodule

// File: rtl/lnk_stat_sticky_hi.sv
module lnk_stat_sticky_hi #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev_i,
  input  logic [N-1:0] qual_i,
  input  logic         clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic nxt;
    always_comb nxt = qual_i[i] & (ev_i[i] | (q_o[i] & ~clr_i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o[i] <= 1'b0;
      else        q_o[i] <= nxt;
    end

    // R6 R7 R8: held until read
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o[i] && !clr_i && qual_i[i]) |=> q_o[i]);
    // R6 R7: qualifier low forces zero
    hold_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !qual_i[i] |=> !q_o[i]);
    // R9: event at read re-latches
    hold_relatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i[i] && qual_i[i]) |=> q_o[i]);
    // R9: read without event clears
    hold_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !ev_i[i]) |=> !q_o[i]);
  end
endmodule

// File: rtl/lnk_stat_sticky_lo.sv
module lnk_stat_sticky_lo (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_i,
  input  logic en_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= en_i & cond_i & (clr_i | q_o);
  end

  // R3: a drop shows on the next clock
  lo_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_i |=> !q_o);
  // R3: a zero stays until read
  lo_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_o && !clr_i) |=> !q_o);
  // R9: read with link up re-arms to one
  lo_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && cond_i && en_i) |=> q_o);
endmodule

// File: rtl/lnk_stat_reg.sv
module lnk_stat_reg
  import lnk_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              transparent_i,
  input  logic              rd_stb_i,
  input  logic              fx_lo_track_i,
  input  logic              fx_freq_err_i,
  input  logic              fx_remote_fault_i,
  input  logic              tp_lo_track_i,
  input  logic              tp_freq_err_i,
  input  logic              seed_stall_i,
  input  logic              tp_link_up_i,
  input  logic              tp_aneg_done_i,
  input  logic              tp_rate100_i,
  input  logic              tp_rate10_i,
  input  logic              tp_pkt_seen_i,
  input  logic              tp_pulse_burst_i,
  input  logic              fx_rate100_i,
  input  logic              fx_rate10_i,
  input  logic              fx_pkt_seen_i,
  input  logic              fx_pulse_burst_i,
  output logic [STAT_W-1:0] status_o
);
  logic              nontr;
  logic [LIVE_N-1:0] live_d, live_q;
  logic [HOLD_N-1:0] hold_ev, hold_qual, hold_q;
  logic              link_q;

  assign nontr = ~transparent_i;

  assign live_d = {fx_lo_track_i, fx_freq_err_i, fx_remote_fault_i,
                   tp_lo_track_i, tp_freq_err_i,
                   tp_aneg_done_i & nontr,
                   tp_rate100_i, tp_rate10_i, tp_pulse_burst_i,
                   fx_rate100_i, fx_rate10_i, fx_pulse_burst_i};

  lnk_stat_live #(.W(LIVE_N)) u_live (
    .clk(clk), .rst_n(rst_n), .d_i(live_d), .q_o(live_q)
  );

  // [2] seed stall, [1] tp packet, [0] fx packet
  assign hold_ev   = {seed_stall_i, tp_pkt_seen_i, fx_pkt_seen_i};
  assign hold_qual = {1'b1, tp_rate100_i | tp_rate10_i,
                      fx_rate100_i | fx_rate10_i};

  lnk_stat_sticky_hi #(.N(HOLD_N)) u_hold (
    .clk(clk), .rst_n(rst_n), .ev_i(hold_ev), .qual_i(hold_qual),
    .clr_i(rd_stb_i), .q_o(hold_q)
  );

  lnk_stat_sticky_lo u_link (
    .clk(clk), .rst_n(rst_n), .cond_i(tp_link_up_i), .en_i(nontr),
    .clr_i(rd_stb_i), .q_o(link_q)
  );

  always_comb begin
    status_o             = '0;
    status_o[B_FX_LO]    = live_q[11];
    status_o[B_FX_FERR]  = live_q[10];
    status_o[B_REM_FLT]  = live_q[9];
    status_o[B_TP_LO]    = live_q[8];
    status_o[B_TP_FERR]  = live_q[7];
    status_o[B_SEED]     = hold_q[2];
    status_o[B_LINK]     = link_q;
    status_o[B_ANEG]     = live_q[6];
    status_o[B_TP_100]   = live_q[5];
    status_o[B_TP_10]    = live_q[4];
    status_o[B_TP_PKT]   = hold_q[1];
    status_o[B_TP_BURST] = live_q[3];
    status_o[B_FX_100]   = live_q[2];
    status_o[B_FX_10]    = live_q[1];
    status_o[B_FX_PKT]   = hold_q[0];
    status_o[B_FX_BURST] = live_q[0];
  end

  // R1
  rst_zero_chk: assert property (@(posedge clk)
    !rst_n |=> status_o == '0);
  // R4
  transp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    transparent_i |=> (!status_o[B_LINK] && !status_o[B_ANEG]));
  // R5
  aneg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tp_aneg_done_i && nontr) |=> status_o[B_ANEG]);
  // R6
  tp_pkt_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[B_TP_PKT] |-> (status_o[B_TP_100] || status_o[B_TP_10]));
  // R7
  fx_pkt_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[B_FX_PKT] |-> (status_o[B_FX_100] || status_o[B_FX_10]));
endmodule

// File: tb/test_lnk_stat_reg.sv
module test_lnk_stat_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic tr = 1'b0;
  logic rd = 1'b0;
  logic [15:0] raw = '0;
  logic [15:0] st;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lnk_stat_reg i_lnk_stat_reg (
    .clk(clk), .rst_n(rst_n), .transparent_i(tr), .rd_stb_i(rd),
    .fx_lo_track_i(raw[15]), .fx_freq_err_i(raw[14]),
    .fx_remote_fault_i(raw[13]), .tp_lo_track_i(raw[12]),
    .tp_freq_err_i(raw[11]), .seed_stall_i(raw[10]),
    .tp_link_up_i(raw[9]), .tp_aneg_done_i(raw[8]),
    .tp_rate100_i(raw[7]), .tp_rate10_i(raw[6]),
    .tp_pkt_seen_i(raw[5]), .tp_pulse_burst_i(raw[4]),
    .fx_rate100_i(raw[3]), .fx_rate10_i(raw[2]),
    .fx_pkt_seen_i(raw[1]), .fx_pulse_burst_i(raw[0]),
    .status_o(st)
  );

  task automatic chk(input string tag, input logic [15:0] got,
                     input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // {transparent, read, raw[15:0], expected status after the edge}
  localparam int NV = 26;
  localparam logic [33:0] VEC [0:NV-1] = '{
    {1'b0, 1'b0, 16'h0000, 16'h0000},  // R2 idle
    {1'b0, 1'b0, 16'h0380, 16'h0180},  // R3 link stays 0 until read; R5
    {1'b0, 1'b1, 16'h0380, 16'h0380},  // R3 read re-arms link
    {1'b0, 1'b0, 16'h03A0, 16'h03A0},  // R6 tp packet latches
    {1'b0, 1'b0, 16'h0380, 16'h03A0},  // R6 held
    {1'b0, 1'b0, 16'h0180, 16'h01A0},  // R3 link drop
    {1'b0, 1'b0, 16'h0380, 16'h01A0},  // R3 link back, still 0
    {1'b0, 1'b1, 16'h0380, 16'h0380},  // R9 read clears tp packet
    {1'b0, 1'b1, 16'h03A0, 16'h03A0},  // R9 read with event re-latches
    {1'b0, 1'b0, 16'h0300, 16'h0300},  // R6 no speed clears
    {1'b0, 1'b0, 16'h0320, 16'h0300},  // R6 packet without speed
    {1'b0, 1'b0, 16'h030A, 16'h030A},  // R7 fiber packet latches
    {1'b0, 1'b0, 16'h0308, 16'h030A},  // R7 held
    {1'b0, 1'b0, 16'h0304, 16'h0306},  // R7 held on 10 Mb/s
    {1'b0, 1'b0, 16'h0300, 16'h0300},  // R7 no speed clears
    {1'b0, 1'b0, 16'h0700, 16'h0700},  // R8 seed stall latches
    {1'b0, 1'b0, 16'h0300, 16'h0700},  // R8 held
    {1'b0, 1'b1, 16'h0300, 16'h0300},  // R8 read clears
    {1'b1, 1'b0, 16'h0300, 16'h0000},  // R4 transparent gates
    {1'b0, 1'b0, 16'h0300, 16'h0100},  // R3 link lost by gating
    {1'b0, 1'b1, 16'h0300, 16'h0300},  // R3 read re-arms
    {1'b0, 1'b0, 16'hFBDD, 16'hFBDD},  // R2 all plain bits
    {1'b1, 1'b0, 16'hFBDD, 16'hF8DD},  // R4 gating with others set
    {1'b1, 1'b0, 16'h0000, 16'h0000},  // R2 all clear
    {1'b0, 1'b1, 16'h0380, 16'h0380},  // R9 read while link up
    {1'b0, 1'b1, 16'h0180, 16'h0180}   // R9 read while link falls
  };

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset", st, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", st, 16'h0000);

    for (int k = 0; k < NV; k++) begin
      tr  = VEC[k][33];
      rd  = VEC[k][32];
      raw = VEC[k][31:16];
      @(negedge clk);
      chk($sformatf("vector %0d", k), st, VEC[k][15:0]);
    end

    // directed: read sampling and re-latch of the seed bit
    tr = 1'b0; rd = 1'b0; raw = 16'h0400;
    @(negedge clk);
    chk("R8 seed set", st, 16'h0400);
    raw = 16'h0000; rd = 1'b1;
    #1;
    chk("R9 read sees held value", st, 16'h0400);
    @(negedge clk);
    chk("R8 cleared by read", st, 16'h0000);
    rd = 1'b0; raw = 16'h0400;
    @(negedge clk);
    rd = 1'b1;
    @(negedge clk);
    chk("R9 re-latch at read", st, 16'h0400);

    // directed: reset in mid-run with every input set
    rd = 1'b0; raw = 16'hFFFF;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset", st, 16'h0000);
    @(negedge clk);
    chk("R1 held in reset", st, 16'h0000);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule